// File: doc/BRIEF.md
# Seconds and Milliseconds Real-Time Counter with Alarm

This block keeps wall time as a seconds count and a milliseconds count. The milliseconds count advances on every pulse of a one-cycle millisecond tick input. When it passes its last value it returns to zero and the seconds count goes up by one. Software can set the time directly through a small register port. The seconds value is written first and is only staged. The following milliseconds write commits the staged pair. The commit lands after a fixed two-tick delay, which stands in for the crossing into a slow always-on domain. While the commit is pending, a busy flag reads as 1.

Reading the running seconds through the shadow address also freezes the running milliseconds into a hold register. A later read of the milliseconds shadow address returns that frozen value, so the two halves software reads always belong to the same instant. An alarm time, also split into seconds and milliseconds, raises a status bit when the running time steps onto it. The interrupt output is that status gated by an enable bit. Writing a one to the clear bit of the control word drops the status.

The commit sequencer has three states:
- `CM_IDLE`: no commit pending. A milliseconds write moves it to `CM_ARMED`.
- `CM_ARMED`: waits for the first tick, then moves to `CM_APPLY`.
- `CM_APPLY`: waits for the second tick. On that tick the staged pair loads and the state returns to `CM_IDLE`.

A milliseconds write in any state sends the sequencer to `CM_ARMED`. That write takes precedence over a tick in the same cycle.

Top module: `secms_rtc`

Register addresses (3-bit):
- 0: control/status.
- 1: staged seconds.
- 2: staged milliseconds and commit.
- 3: alarm seconds.
- 4: alarm milliseconds.
- 5: seconds shadow.
- 6: milliseconds hold.
- 7: unused.

Control word bits:
- bit 0: enable.
- bit 1: clear (write-only, reads 0).
- bit 2: status.
- bit 3: busy.

## Requirements
- R1: After reset every readable address (0 to 7) returns 0 and `irq` is 0.
- R2: Each cycle with `ms_tick` high adds one to the milliseconds count. If the count is 999 or more before the tick, it becomes 0 and seconds increase by one. Without a tick, and with no commit landing, the time is unchanged.
- R3: A write to address 1 only stages a seconds value. The running time does not change, and address 1 reads back the staged value.
- R4: A write to address 2 stages milliseconds and starts a commit. Busy (control bit 3) reads 1 from the next cycle until the second later tick. On that tick the running time takes the staged seconds and milliseconds instead of counting, and busy reads 0 afterwards.
- R5: A write to address 2 while a commit is pending restarts the two-tick wait with the new value. A tick in the same cycle as that write does not count toward the wait.
- R6: Address 5 returns the running seconds. A read of address 5 with `reg_rd` high captures the running milliseconds in the same cycle. Address 6 returns that captured value unchanged until the next such read.
- R7: Addresses 3 and 4 hold the alarm time. Status (control bit 2) sets one cycle after the running time changes to equal the alarm while enable is 1. It does not set while enable is 0, and it is not raised again while the time stays on the alarm value.
- R8: Writing the control word with bit 1 set clears status, unless a new alarm hit occurs in that same cycle, in which case status stays 1. Bit 1 reads 0.
- R9: `irq` equals status AND enable.
- R10: Address 7 reads 0. Writes to addresses 5, 6 and 7 change no readable state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ms_tick | input | 1 | One-cycle millisecond pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_waddr | input | ADDR_W | Write address |
| reg_wdata | input | DATA_W | Write data |
| reg_rd | input | 1 | Read strobe (captures the milliseconds hold on address 5) |
| reg_raddr | input | ADDR_W | Read address |
| reg_rdata | output | DATA_W | Read data for `reg_raddr`, combinational |
| irq | output | 1 | Alarm interrupt |

## Verification
The bench checks several timing corners.

- It issues a milliseconds write in the same cycle as a tick, and again during an open commit. A sequencer that counted that tick, or that ignored the restart, would load early or load the stale value.
- It loads a milliseconds value above 999 to prove that rollover uses a threshold rather than an equality. An equality test would let the count run on past 999.
- It parks the time on the alarm and clears status. A level-sensitive comparator would set status again at once.
- It lands a clear in the exact cycle of a new hit, which a clear-priority design would lose.
- It checks that ticks after a seconds-shadow read leave the frozen milliseconds alone. A directly wired shadow would show torn pairs.

// File: rtl/secms_rtc_pkg.sv
package secms_rtc_pkg;

    typedef enum logic [1:0] {
        CM_IDLE  = 2'd0,
        CM_ARMED = 2'd1,
        CM_APPLY = 2'd2
    } commit_state_e;

    localparam int A_CTRL    = 0;
    localparam int A_SEC     = 1;
    localparam int A_MS      = 2;
    localparam int A_ALM_SEC = 3;
    localparam int A_ALM_MS  = 4;
    localparam int A_SHD_SEC = 5;
    localparam int A_SHD_MS  = 6;

    localparam int B_EN     = 0;
    localparam int B_CLR    = 1;
    localparam int B_STATUS = 2;
    localparam int B_BUSY   = 3;

endpackage

// File: rtl/secms_commit_fsm.sv
module secms_commit_fsm
    import secms_rtc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic tick,
    output logic busy,
    output logic load
);

    commit_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (start) begin
            state_d = CM_ARMED;
        end else begin
            unique case (state_q)
                CM_IDLE:  state_d = CM_IDLE;
                CM_ARMED: if (tick) state_d = CM_APPLY;
                CM_APPLY: if (tick) state_d = CM_IDLE;
                default:  state_d = CM_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CM_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        busy = 1'b0;
        load = 1'b0;
        unique case (state_q)
            CM_IDLE:  busy = 1'b0;
            CM_ARMED: busy = 1'b1;
            CM_APPLY: begin
                busy = 1'b1;
                load = tick & ~start;
            end
            default:  busy = 1'b0;
        endcase
    end

    a_r5_restart_rearms: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (busy && !load));
    a_r4_release_after_load: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !start) |=> !busy);
    a_r4_no_load_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> !load);

endmodule

// File: rtl/secms_time_counter.sv
module secms_time_counter #(
    parameter int SEC_W   = 32,
    parameter int MS_W    = 10,
    parameter int MS_LAST = 999
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load,
    input  logic [SEC_W-1:0] load_sec,
    input  logic [MS_W-1:0]  load_ms,
    output logic [SEC_W-1:0] cnt_sec,
    output logic [MS_W-1:0]  cnt_ms
);

    localparam logic [MS_W-1:0] MS_LAST_V = MS_W'(MS_LAST);

    logic wrap;
    assign wrap = (cnt_ms >= MS_LAST_V);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_sec <= '0;
            cnt_ms  <= '0;
        end else if (load) begin
            cnt_sec <= load_sec;
            cnt_ms  <= load_ms;
        end else if (tick) begin
            if (wrap) begin
                cnt_ms  <= '0;
                cnt_sec <= cnt_sec + SEC_W'(1);
            end else begin
                cnt_ms  <= cnt_ms + MS_W'(1);
            end
        end
    end

    a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !load) |=> ($stable(cnt_ms) && $stable(cnt_sec)));
    a_r2_rollover: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load && cnt_ms >= MS_LAST_V) |=>
            (cnt_ms == '0 && cnt_sec == $past(cnt_sec) + SEC_W'(1)));
    a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load && cnt_ms < MS_LAST_V) |=>
            (cnt_ms == $past(cnt_ms) + MS_W'(1) && $stable(cnt_sec)));
    a_r4_load_value: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt_ms == $past(load_ms) && cnt_sec == $past(load_sec)));

endmodule

// File: rtl/secms_alarm_irq.sv
module secms_alarm_irq #(
    parameter int SEC_W = 32,
    parameter int MS_W  = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEC_W-1:0] cnt_sec,
    input  logic [MS_W-1:0]  cnt_ms,
    input  logic [SEC_W-1:0] alm_sec,
    input  logic [MS_W-1:0]  alm_ms,
    input  logic             en,
    input  logic             clr,
    output logic             status,
    output logic             irq
);

    logic match, match_d, hit;

    assign match = (cnt_sec == alm_sec) && (cnt_ms == alm_ms);
    assign hit   = en & match & ~match_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            match_d <= 1'b0;
            status  <= 1'b0;
        end else begin
            match_d <= match;
            status  <= (status & ~clr) | hit;
        end
    end

    assign irq = status & en;

    a_r7_quiet_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !$rose(status));
    a_r7_rise_needs_match: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status) |-> match_d);
    a_r8_clear_effective: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (!status || match_d));

endmodule

// File: rtl/secms_rtc.sv
module secms_rtc
    import secms_rtc_pkg::*;
#(
    parameter int SEC_W   = 32,
    parameter int MS_W    = 10,
    parameter int MS_LAST = 999,
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ms_tick,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_waddr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_raddr,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq
);

    logic [SEC_W-1:0] stg_sec, alm_sec, cnt_sec;
    logic [MS_W-1:0]  stg_ms, alm_ms, cnt_ms, ms_hold;
    logic             en_q, status, busy, load;
    logic             wr_ctrl, wr_sec, wr_ms, wr_asec, wr_ams, clr, cap;

    assign wr_ctrl = reg_wr && (reg_waddr == ADDR_W'(A_CTRL));
    assign wr_sec  = reg_wr && (reg_waddr == ADDR_W'(A_SEC));
    assign wr_ms   = reg_wr && (reg_waddr == ADDR_W'(A_MS));
    assign wr_asec = reg_wr && (reg_waddr == ADDR_W'(A_ALM_SEC));
    assign wr_ams  = reg_wr && (reg_waddr == ADDR_W'(A_ALM_MS));
    assign clr     = wr_ctrl && reg_wdata[B_CLR];
    assign cap     = reg_rd && (reg_raddr == ADDR_W'(A_SHD_SEC));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg_sec <= '0;
            stg_ms  <= '0;
            alm_sec <= '0;
            alm_ms  <= '0;
            en_q    <= 1'b0;
            ms_hold <= '0;
        end else begin
            if (wr_sec)  stg_sec <= reg_wdata[SEC_W-1:0];
            if (wr_ms)   stg_ms  <= reg_wdata[MS_W-1:0];
            if (wr_asec) alm_sec <= reg_wdata[SEC_W-1:0];
            if (wr_ams)  alm_ms  <= reg_wdata[MS_W-1:0];
            if (wr_ctrl) en_q    <= reg_wdata[B_EN];
            if (cap)     ms_hold <= cnt_ms;
        end
    end

    secms_commit_fsm u_commit (
        .clk   (clk),
        .rst_n (rst_n),
        .start (wr_ms),
        .tick  (ms_tick),
        .busy  (busy),
        .load  (load)
    );

    secms_time_counter #(
        .SEC_W   (SEC_W),
        .MS_W    (MS_W),
        .MS_LAST (MS_LAST)
    ) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (ms_tick),
        .load     (load),
        .load_sec (stg_sec),
        .load_ms  (stg_ms),
        .cnt_sec  (cnt_sec),
        .cnt_ms   (cnt_ms)
    );

    secms_alarm_irq #(
        .SEC_W (SEC_W),
        .MS_W  (MS_W)
    ) u_alarm (
        .clk     (clk),
        .rst_n   (rst_n),
        .cnt_sec (cnt_sec),
        .cnt_ms  (cnt_ms),
        .alm_sec (alm_sec),
        .alm_ms  (alm_ms),
        .en      (en_q),
        .clr     (clr),
        .status  (status),
        .irq     (irq)
    );

    always_comb begin
        reg_rdata = '0;
        case (reg_raddr)
            ADDR_W'(A_CTRL): begin
                reg_rdata[B_EN]     = en_q;
                reg_rdata[B_STATUS] = status;
                reg_rdata[B_BUSY]   = busy;
            end
            ADDR_W'(A_SEC):     reg_rdata = DATA_W'(stg_sec);
            ADDR_W'(A_MS):      reg_rdata = DATA_W'(stg_ms);
            ADDR_W'(A_ALM_SEC): reg_rdata = DATA_W'(alm_sec);
            ADDR_W'(A_ALM_MS):  reg_rdata = DATA_W'(alm_ms);
            ADDR_W'(A_SHD_SEC): reg_rdata = DATA_W'(cnt_sec);
            ADDR_W'(A_SHD_MS):  reg_rdata = DATA_W'(ms_hold);
            default:            reg_rdata = '0;
        endcase
    end

    a_r4_busy_after_commit: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ms |=> busy);
    a_r6_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !cap |=> $stable(ms_hold));
    a_r9_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |-> !irq);

endmodule

// File: tb/secms_rtc_tb_top.sv
module secms_rtc_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ms_tick = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_waddr = '0;
    logic [31:0] reg_wdata = '0;
    logic        reg_rd = 1'b0;
    logic [2:0]  reg_raddr = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int tests = 0;
    int fails = 0;
    bit done = 0;

    always #10 clk = ~clk;

    secms_rtc dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .ms_tick   (ms_tick),
        .reg_wr    (reg_wr),
        .reg_waddr (reg_waddr),
        .reg_wdata (reg_wdata),
        .reg_rd    (reg_rd),
        .reg_raddr (reg_raddr),
        .reg_rdata (reg_rdata),
        .irq       (irq)
    );

    // behavioural reference model
    int unsigned m_sec = 0, m_ms = 0, m_ssec = 0, m_sms = 0;
    int unsigned m_asec = 0, m_ams = 0, m_hold = 0;
    int          m_wait = 0;
    bit          m_en = 0, m_st = 0, m_md = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_sec = 0; m_ms = 0; m_ssec = 0; m_sms = 0;
            m_asec = 0; m_ams = 0; m_hold = 0; m_wait = 0;
            m_en = 0; m_st = 0; m_md = 0;
        end else begin
            bit match, hit, clr, ld;
            int unsigned nsec, nms;
            match = (m_sec == m_asec) && (m_ms == m_ams);
            hit   = m_en && match && !m_md;
            clr   = reg_wr && reg_waddr == 0 && reg_wdata[1];
            ld    = (m_wait == 1) && ms_tick && !(reg_wr && reg_waddr == 2);
            nsec = m_sec; nms = m_ms;
            if (ld) begin
                nsec = m_ssec; nms = m_sms;
            end else if (ms_tick) begin
                if (m_ms >= 999) begin nms = 0; nsec = m_sec + 1; end
                else nms = m_ms + 1;
            end
            if (reg_rd && reg_raddr == 5) m_hold = m_ms;
            if (reg_wr && reg_waddr == 2) m_wait = 2;
            else if (ms_tick && m_wait > 0) m_wait = m_wait - 1;
            m_st = (m_st && !clr) || hit;
            m_md = match;
            if (reg_wr) begin
                case (reg_waddr)
                    3'd0: m_en = reg_wdata[0];
                    3'd1: m_ssec = reg_wdata;
                    3'd2: m_sms = reg_wdata[9:0];
                    3'd3: m_asec = reg_wdata;
                    3'd4: m_ams = reg_wdata[9:0];
                    default: ;
                endcase
            end
            m_sec = nsec; m_ms = nms;
        end
    end

    function automatic logic [31:0] model_rd(input logic [2:0] a);
        case (a)
            3'd0: return {28'd0, (m_wait > 0), m_st, 1'b0, m_en};
            3'd1: return m_ssec;
            3'd2: return m_sms;
            3'd3: return m_asec;
            3'd4: return m_ams;
            3'd5: return m_sec;
            3'd6: return m_hold;
            default: return 32'd0;
        endcase
    endfunction

    function automatic string req_of(input logic [2:0] a);
        case (a)
            3'd0: return "R4";
            3'd1: return "R3";
            3'd2: return "R4";
            3'd3, 3'd4: return "R7";
            3'd5, 3'd6: return "R6";
            default: return "R10";
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // drive one cycle, then compare with the model away from the edge
    task automatic step(input bit w, input int a, input int d, input bit re,
                        input int ra, input bit tk);
        reg_wr = w; reg_waddr = 3'(a); reg_wdata = 32'(d);
        reg_rd = re; reg_raddr = 3'(ra); ms_tick = tk;
        @(negedge clk);
        chk(req_of(reg_raddr), reg_rdata, model_rd(reg_raddr));
        chk("R9", {31'd0, irq}, {31'd0, m_st && m_en});
    endtask

    task automatic tick1();
        step(0, 0, 0, 0, 0, 1);
    endtask

    task automatic rd(input int ra, input bit re);
        step(0, 0, 0, re, ra, 0);
    endtask

    initial begin
        #3000000;
        if (!done) begin
            fails++;
            $display("FAIL R1 watchdog: actual hung expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        for (int a = 0; a < 8; a++) begin
            rd(a, 0);
            chk("R1", reg_rdata, 32'd0);
        end
        chk("R1", {31'd0, irq}, 32'd0);
        // R2 / R6 counting and coherent hold
        repeat (5) tick1();
        rd(5, 1); chk("R6", reg_rdata, 32'd0);
        repeat (3) tick1();
        rd(6, 0); chk("R6", reg_rdata, 32'd5);
        // R3 staging
        step(1, 1, 7, 0, 1, 0); chk("R3", reg_rdata, 32'd7);
        rd(5, 0); chk("R3", reg_rdata, 32'd0);
        // R4 commit
        step(1, 2, 997, 0, 0, 0); chk("R4", reg_rdata, 32'd8);
        tick1(); chk("R4", reg_rdata, 32'd8);
        rd(0, 0); chk("R4", reg_rdata, 32'd8);
        tick1(); chk("R4", reg_rdata, 32'd0);
        rd(5, 1); chk("R4", reg_rdata, 32'd7);
        rd(6, 0); chk("R4", reg_rdata, 32'd997);
        repeat (3) tick1();
        rd(5, 1); chk("R2", reg_rdata, 32'd8);
        rd(6, 0); chk("R2", reg_rdata, 32'd0);
        // R5 restart, tick alongside the write is not counted
        step(1, 1, 20, 0, 0, 0);
        step(1, 2, 100, 0, 0, 0);
        tick1();
        step(1, 2, 200, 0, 0, 1);
        tick1();
        rd(0, 0); chk("R5", reg_rdata, 32'd8);
        rd(5, 0); chk("R5", reg_rdata, 32'd8);
        tick1();
        rd(5, 1); chk("R5", reg_rdata, 32'd20);
        rd(6, 0); chk("R5", reg_rdata, 32'd200);
        // R7 alarm while disabled
        step(1, 3, 20, 0, 0, 0);
        step(1, 4, 203, 0, 0, 0);
        repeat (5) tick1();
        rd(0, 0); chk("R7", reg_rdata, 32'd0);
        step(1, 0, 1, 0, 0, 0); chk("R7", reg_rdata, 32'd1);
        step(1, 2, 200, 0, 0, 0);
        tick1(); tick1();
        tick1(); tick1(); tick1();
        chk("R7", {31'd0, irq}, 32'd0);
        rd(0, 0); chk("R7", reg_rdata, 32'd5); chk("R9", {31'd0, irq}, 32'd1);
        rd(0, 0); rd(0, 0);
        // R8 clear while parked on alarm, no re-raise
        step(1, 0, 3, 0, 0, 0); chk("R8", reg_rdata, 32'd1);
        repeat (3) rd(0, 0);
        chk("R8", reg_rdata, 32'd1); chk("R7", {31'd0, irq}, 32'd0);
        // R9 gating by enable
        step(1, 2, 202, 0, 0, 0);
        tick1(); tick1(); tick1();
        rd(0, 0); chk("R9", reg_rdata, 32'd5);
        step(1, 0, 0, 0, 0, 0); chk("R9", reg_rdata, 32'd4); chk("R9", {31'd0, irq}, 32'd0);
        step(1, 0, 1, 0, 0, 0); chk("R9", {31'd0, irq}, 32'd1);
        // R8 clear coincides with new hit
        step(1, 2, 202, 0, 0, 0);
        tick1(); tick1(); tick1();
        step(1, 0, 3, 0, 0, 0); chk("R8", reg_rdata, 32'd5);
        step(1, 0, 3, 0, 0, 0); chk("R8", reg_rdata, 32'd1);
        // R2 threshold rollover from an out-of-range load
        step(1, 1, 3, 0, 0, 0);
        step(1, 2, 1010, 0, 0, 0);
        tick1(); tick1(); tick1();
        rd(5, 1); chk("R2", reg_rdata, 32'd4);
        rd(6, 0); chk("R2", reg_rdata, 32'd0);
        // R2 natural rollover
        repeat (1000) tick1();
        rd(5, 1); chk("R2", reg_rdata, 32'd5);
        rd(6, 0); chk("R2", reg_rdata, 32'd0);
        // R10 read-only and unused addresses
        step(1, 5, 99, 0, 0, 0);
        step(1, 6, 99, 0, 0, 0);
        step(1, 7, 99, 0, 0, 0);
        rd(5, 1); chk("R10", reg_rdata, 32'd5);
        rd(6, 0); chk("R10", reg_rdata, 32'd0);
        rd(7, 0); chk("R10", reg_rdata, 32'd0);
        rd(3, 0); chk("R10", reg_rdata, 32'd20);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule